// File: doc/BRIEF.md
# Remote Code Receive Qualifier

This block is the receive side of a remote-control address decoder. A sampling front end, not part of this block, presents each received word as a word-start marker followed by one strobe per data bit. The block compares every incoming bit, as it arrives, against a 12-bit locally configured address. A word whose twelve bits all agree produces a single-cycle valid pulse. A wrong bit spoils the word, and the comparator waits for the next word-start.

Valid pulses feed a run tracker and a window timer that counts a 1 ms tick. The active-low detect output goes low only after four matching words in a row, each arriving no more than 64 ticks after the previous one. Once detect is low, the allowed gap widens to 128 ticks. A gap that runs out drops detect, empties the run, and a fresh run of four is then needed. This rejects stray words from nearby transmitters while holding a steady output during continuous reception.

Top module: `remote_code_qualifier`

## Requirements
- R1: After a synchronous active-high reset, detect_n is 1 and neither valid_pulse nor timeout_pulse is high.
- R2: The k-th bit strobe after a word-start (k counted from 0) is compared with local_code[k], so the least significant address bit comes first. A word whose 12 bits all match raises valid_pulse for exactly one cycle, in the cycle after the 12th strobe.
- R3: A word with any mismatching bit, including only the first or only the last, produces no valid_pulse.
- R4: A word-start resets the bit position and clears a pending mismatch. Strobes after the 12th strobe of a word have no effect until the next word-start.
- R5: detect_n goes low in the cycle after the valid_pulse of the fourth valid word of a run.
- R6: While detect_n is high and the run is not empty, the 64th tick with no valid word gives a one-cycle timeout_pulse and empties the run. A valid word after 63 ticks still extends the run.
- R7: While detect_n is low, a valid word arriving at most 127 ticks after the previous one keeps detect_n low.
- R8: While detect_n is low, the 128th tick with no valid word gives a timeout_pulse, drives detect_n high and empties the run, so four new valid words are needed.
- R9: With an empty run and detect_n high, ticks produce no timeout_pulse.
- R10: Each valid_pulse restarts the tick count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| word_start | input | 1 | Marks the beginning of a received word |
| bit_strobe | input | 1 | One-cycle strobe qualifying bit_data |
| bit_data | input | 1 | Sampled received bit |
| local_code | input | 12 | Locally configured address |
| valid_pulse | output | 1 | One-cycle pulse for a fully matching word |
| timeout_pulse | output | 1 | One-cycle pulse when the gap window expires |
| detect_n | output | 1 | Active-low qualified-link output |

## Verification
Matching words are sent at gaps of 0, 10, 20, 63 and 127 ticks, against words spoiled in the first bit only or in the last bit only. This separates a correct bit order and a full-word check from a comparator that stops early or samples the wrong position. Gaps of exactly 64 ticks before detect and 128 ticks after it probe each window edge from the failing side. A run that needs four further words after a 64-tick expiry shows that the expiry really emptied the count. Overrun strobes, a restart in mid-word, and two 60-tick gaps separate a timer that restarts on each valid word from one that keeps counting.

// File: rtl/rcq_pkg.sv
package rcq_pkg;

    localparam int unsigned ADDR_BITS   = 12;
    localparam int unsigned SHORT_GAP   = 64;
    localparam int unsigned LONG_GAP    = 128;
    localparam int unsigned RUN_TARGET  = 4;

    // Width needed to hold the values 0..n
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    localparam int unsigned POS_W = span_bits(ADDR_BITS);
    localparam int unsigned GAP_W = span_bits(LONG_GAP);
    localparam int unsigned RUN_W = span_bits(RUN_TARGET);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             spoiled;
    } match_state_t;

    typedef struct packed {
        logic [RUN_W-1:0] count;
        logic             locked;
    } run_state_t;

endpackage

// File: rtl/rcq_bit_matcher.sv
module rcq_bit_matcher
    import rcq_pkg::*;
#(
    parameter int unsigned N_BITS = ADDR_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_start,
    input  logic              bit_strobe,
    input  logic              bit_data,
    input  logic [N_BITS-1:0] local_code,
    output logic              word_ok
);
    localparam int unsigned PW = span_bits(N_BITS);
    localparam logic [PW-1:0] LAST_POS = PW'(N_BITS - 1);
    localparam logic [PW-1:0] DONE_POS = PW'(N_BITS);

    logic [PW-1:0] pos_q;
    logic          spoiled_q;
    logic          ok_q;
    logic          bit_agrees;

    always_comb begin
        bit_agrees = 1'b0;
        for (int i = 0; i < int'(N_BITS); i++) begin
            if (pos_q == PW'(i)) bit_agrees = (bit_data == local_code[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            spoiled_q <= 1'b0;
            ok_q      <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            if (word_start) begin
                pos_q     <= '0;
                spoiled_q <= 1'b0;
            end else if (bit_strobe && pos_q != DONE_POS) begin
                pos_q <= pos_q + 1'b1;
                if (!bit_agrees) begin
                    spoiled_q <= 1'b1;
                end else if (pos_q == LAST_POS && !spoiled_q) begin
                    ok_q <= 1'b1;
                end
            end
        end
    end

    assign word_ok = ok_q;

    assert_single_valid_R2: assert property (@(posedge clk) disable iff (rst)
        ok_q |=> !ok_q);

    assert_spoiled_no_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (spoiled_q && !word_start) |=> !ok_q);

    assert_pos_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        pos_q <= DONE_POS);

    assert_valid_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> pos_q == DONE_POS);

endmodule

// File: rtl/rcq_gap_timer.sv
module rcq_gap_timer
    import rcq_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = SHORT_GAP,
    parameter int unsigned LONG_TICKS  = LONG_GAP
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    input  logic armed,
    input  logic wide,
    output logic expired
);
    localparam int unsigned CW = span_bits(LONG_TICKS);
    localparam logic [CW-1:0] SHORT_END = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] LONG_END  = CW'(LONG_TICKS - 1);

    logic [CW-1:0] ticks_q;
    logic          expired_q;
    logic [CW-1:0] end_val;

    assign end_val = wide ? LONG_END : SHORT_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_q   <= '0;
            expired_q <= 1'b0;
        end else begin
            expired_q <= 1'b0;
            if (restart || !armed) begin
                ticks_q <= '0;
            end else if (tick) begin
                if (ticks_q == end_val) begin
                    ticks_q   <= '0;
                    expired_q <= 1'b1;
                end else begin
                    ticks_q <= ticks_q + 1'b1;
                end
            end
        end
    end

    assign expired = expired_q;

    assert_single_timeout_R6: assert property (@(posedge clk) disable iff (rst)
        expired_q |=> !expired_q);

    assert_idle_no_timeout_R9: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !expired_q);

    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (ticks_q == '0 && !expired_q));

    assert_count_in_window_R7: assert property (@(posedge clk) disable iff (rst)
        ticks_q <= LONG_END);

endmodule

// File: rtl/rcq_run_tracker.sv
module rcq_run_tracker
    import rcq_pkg::*;
#(
    parameter int unsigned RUN_LEN = RUN_TARGET
) (
    input  logic clk,
    input  logic rst,
    input  logic word_ok,
    input  logic expired,
    output logic armed,
    output logic locked
);
    localparam int unsigned RW = span_bits(RUN_LEN);
    localparam logic [RW-1:0] FULL     = RW'(RUN_LEN);
    localparam logic [RW-1:0] PRE_FULL = RW'(RUN_LEN - 1);

    logic [RW-1:0] count_q;
    logic          locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            locked_q <= 1'b0;
        end else if (expired) begin
            count_q  <= word_ok ? RW'(1) : '0;
            locked_q <= 1'b0;
        end else if (word_ok) begin
            if (count_q != FULL) count_q <= count_q + 1'b1;
            if (count_q == PRE_FULL) locked_q <= 1'b1;
        end
    end

    assign armed  = (count_q != '0);
    assign locked = locked_q;

    assert_lock_on_fourth_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> ($past(word_ok) && $past(count_q) == PRE_FULL));

    assert_expiry_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (expired && !word_ok) |=> (count_q == '0 && !locked_q));

    assert_count_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL);

    assert_lock_only_full_R7: assert property (@(posedge clk) disable iff (rst)
        locked_q |-> count_q == FULL);

endmodule

// File: rtl/remote_code_qualifier.sv
module remote_code_qualifier
    import rcq_pkg::*;
#(
    parameter int unsigned N_BITS      = ADDR_BITS,
    parameter int unsigned SHORT_TICKS = SHORT_GAP,
    parameter int unsigned LONG_TICKS  = LONG_GAP,
    parameter int unsigned RUN_LEN     = RUN_TARGET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ms_tick,
    input  logic              word_start,
    input  logic              bit_strobe,
    input  logic              bit_data,
    input  logic [N_BITS-1:0] local_code,
    output logic              valid_pulse,
    output logic              timeout_pulse,
    output logic              detect_n
);
    logic word_ok;
    logic expired;
    logic armed;
    logic locked;

    rcq_bit_matcher #(.N_BITS(N_BITS)) u_matcher (
        .clk        (clk),
        .rst        (rst),
        .word_start (word_start),
        .bit_strobe (bit_strobe),
        .bit_data   (bit_data),
        .local_code (local_code),
        .word_ok    (word_ok)
    );

    rcq_gap_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .restart (word_ok),
        .armed   (armed),
        .wide    (locked),
        .expired (expired)
    );

    rcq_run_tracker #(.RUN_LEN(RUN_LEN)) u_tracker (
        .clk     (clk),
        .rst     (rst),
        .word_ok (word_ok),
        .expired (expired),
        .armed   (armed),
        .locked  (locked)
    );

    assign valid_pulse   = word_ok;
    assign timeout_pulse = expired;
    assign detect_n      = !locked;

    assert_reset_outputs_R1: assert property (@(posedge clk)
        rst |=> (detect_n && !valid_pulse && !timeout_pulse));

endmodule

// File: tb/remote_code_qualifier_tb.sv
module remote_code_qualifier_tb;

    localparam logic [11:0] CODE = 12'hA5C;
    localparam int NV = 13;

    // ticks before word, flip mask, expected valid/timeout deltas, expected detect_n
    localparam int          GAP  [NV] = '{0, 10, 63, 20, 100, 127, 5, 5, 118, 64, 0, 0, 0};
    localparam logic [11:0] FLIP [NV] = '{12'h000, 12'h000, 12'h000, 12'h000, 12'h000,
                                          12'h000, 12'h001, 12'h800, 12'h000, 12'h000,
                                          12'h000, 12'h000, 12'h000};
    localparam int          EV   [NV] = '{1, 1, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 1};
    localparam int          ET   [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
    localparam logic        EDN  [NV] = '{1, 1, 1, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0};
    localparam string       TAG  [NV] = '{"R2", "R2", "R6", "R5", "R7", "R7", "R3", "R3",
                                          "R8", "R6", "R6", "R6", "R5"};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ms_tick = 1'b0;
    logic word_start = 1'b0;
    logic bit_strobe = 1'b0;
    logic bit_data = 1'b0;
    logic [11:0] local_code = CODE;
    logic valid_pulse, timeout_pulse, detect_n;

    int tests = 0;
    int fails = 0;
    int v_cnt = 0;
    int t_cnt = 0;

    always #10 clk = ~clk;

    remote_code_qualifier u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .word_start(word_start),
        .bit_strobe(bit_strobe), .bit_data(bit_data), .local_code(local_code),
        .valid_pulse(valid_pulse), .timeout_pulse(timeout_pulse), .detect_n(detect_n)
    );

    always @(negedge clk) begin
        if (!rst && valid_pulse)   v_cnt++;
        if (!rst && timeout_pulse) t_cnt++;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic send_bits(input logic [11:0] w, input int n);
        @(negedge clk) word_start = 1'b1;
        @(negedge clk) word_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_strobe = 1'b1;
            bit_data   = w[i];
            @(negedge clk);
        end
        bit_strobe = 1'b0;
        bit_data   = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int v0, t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "detect_n after reset", int'(detect_n), 1);
        check("R1", "valid_pulse in reset", int'(valid_pulse), 0);
        check("R1", "timeout_pulse in reset", int'(timeout_pulse), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            v0 = v_cnt;
            t0 = t_cnt;
            ticks(GAP[k]);
            send_bits(CODE ^ FLIP[k], 12);
            settle();
            check(TAG[k], $sformatf("row %0d valid count", k), v_cnt - v0, EV[k]);
            check(TAG[k], $sformatf("row %0d timeout count", k), t_cnt - t0, ET[k]);
            check(TAG[k], $sformatf("row %0d detect_n", k), int'(detect_n), int'(EDN[k]));
        end

        // R1: reset while detected
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", "detect_n after mid-run reset", int'(detect_n), 1);
        rst = 1'b0;

        // R9: idle ticks with empty run
        t0 = t_cnt;
        ticks(200);
        check("R9", "timeouts while idle", t_cnt - t0, 0);

        // R4: overrun strobes after a full word
        v0 = v_cnt;
        send_bits(CODE, 12);
        for (int i = 0; i < 3; i++) begin
            bit_strobe = 1'b1;
            bit_data   = CODE[i];
            @(negedge clk);
        end
        bit_strobe = 1'b0;
        settle();
        check("R4", "valids with overrun strobes", v_cnt - v0, 1);

        // R4: restart mid-word clears the mismatch
        v0 = v_cnt;
        send_bits(~CODE, 5);
        send_bits(CODE, 12);
        settle();
        check("R4", "valid after mid-word restart", v_cnt - v0, 1);

        // R10: valid restarts the count (two 60-tick gaps)
        t0 = t_cnt;
        ticks(60);
        send_bits(CODE, 12);
        settle();
        ticks(60);
        send_bits(CODE, 12);
        settle();
        check("R10", "no timeout across 120 ticks", t_cnt - t0, 0);
        check("R5", "detect_n after fourth valid", int'(detect_n), 0);

        // R8: 128 ticks with detect low
        t0 = t_cnt;
        ticks(127);
        check("R8", "detect_n held at 127 ticks", int'(detect_n), 0);
        ticks(1);
        settle();
        check("R8", "timeout at 128 ticks", t_cnt - t0, 1);
        check("R8", "detect_n after long expiry", int'(detect_n), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule